// File: doc/BRIEF.md
# Segmented Constant-Coefficient Table Multiplier

This block multiplies an unsigned input word by a coefficient fixed at elaboration time. It does not use a general multiplier. The input is cut into fixed-width segments. Each upper segment goes to a compact table core, which stores only the odd multiples of the coefficient for half the segment range. A barrel shift rebuilds the even multiples, and a conditional negation applies the sign that the segment's top bit selects.

The least significant segment reads a small full table instead. Every entry of that table also carries the sum of the offset terms that the compact cores leave out. The compact outputs therefore need only a sign change and never a correction of their own. All partial products are shifted to their segment weight and summed modulo the product width. The result leaves through an output register, and a parameter can add one more register stage ahead of the adder tree.

Inputs are accepted on every cycle in which the valid input is high. The result and its valid flag appear a fixed number of cycles later, and the output holds its value between valid results.

Top module: `lutmul_seg_top`

## Requirements
- R1: When `out_valid` is high, `prod_out` equals COEF × X, where X is the `x_in` value accepted LAT cycles earlier. LAT is 1 when PIPE = 0 and 2 when PIPE = 1. One input is accepted per cycle with no gaps.
- R2: `out_valid` equals `in_valid` delayed by LAT cycles. While reset is low, `out_valid` and `prod_out` are 0.
- R3: `x_in` splits into NOPT = (XW−1)/S upper segments of S bits and one low segment of SL = XW − NOPT·S bits. Upper segment j occupies bits [SL + j·S +: S] and carries weight 2^(SL + j·S).
- R4: For an upper segment value u, the compact core yields u·COEF − 2^(S−1)·COEF. The result is non-negative when the segment's top bit is 1 and negative otherwise.
- R5: A segment value with only its top bit set yields a zero partial product without reading the odd-multiple table.
- R6: A segment value of zero yields −2^(S−1)·COEF. The core forms this as the stored entry COEF shifted left by S−1.
- R7: The low-segment table holds COEF·v + V for each low value v. V is the sum over the upper segments of 2^(S−1)·COEF·2^(SL + j·S), taken modulo 2^(XW+AW).
- R8: In a cycle where `out_valid` is low, `prod_out` keeps its previous value.
- R9: X = 0 gives 0, and X = all ones gives COEF·(2^XW − 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Marks `x_in` as an operand to multiply |
| x_in | input | XW | Unsigned multiplicand |
| out_valid | output | 1 | Marks `prod_out` as a fresh product |
| prod_out | output | XW+AW | Unsigned product COEF × X |

## Verification
The bench builds three instances. The first is the default 16-bit, 4-bit-segment build with an odd coefficient and PIPE = 1. The second is a 10-bit input with 4-bit segments, an odd 6-bit coefficient and PIPE = 0. The third is an 8-bit input with 3-bit segments, an even coefficient and PIPE = 1. The two small builds are driven through every input value, which brings every segment code within reach: the midpoint, zero, and every odd/shift pair. Every low-segment table entry and both latency settings are also covered. The wide build receives the corner patterns and a long random stream with gaps in the valid input.

// File: rtl/lutmul_pkg.sv
package lutmul_pkg;

    // number of compact (upper) segments
    function automatic int unsigned lm_nopt(input int unsigned xw, input int unsigned s);
        return (xw - 1) / s;
    endfunction

    // width of the low segment served by the full table
    function automatic int unsigned lm_low_w(input int unsigned xw, input int unsigned s);
        return xw - ((xw - 1) / s) * s;
    endfunction

endpackage

// File: rtl/lutmul_addr_gen.sv
module lutmul_addr_gen #(
    parameter int unsigned S  = 4,
    localparam int unsigned SW = $clog2(S),
    localparam int unsigned IW = S - 2
) (
    input  logic [S-1:0]  sub_in,
    output logic [IW-1:0] idx_o,
    output logic [SW-1:0] shift_o,
    output logic          blank_o,
    output logic          neg_o
);
    localparam logic [S-1:0] HALFV = S'(1) << (S - 1);

    logic [S-1:0] mag_m;
    logic [S-1:0] odd_m;

    // distance of the segment from the midpoint of its range
    always_comb begin
        if (sub_in[S-1]) begin
            mag_m = {1'b0, sub_in[S-2:0]};
        end else begin
            mag_m = HALFV - {1'b0, sub_in[S-2:0]};
        end
    end

    // strip trailing zeros: the lowest set bit gives the shift count
    always_comb begin
        shift_o = '0;
        for (int i = S - 1; i >= 0; i--) begin
            if (mag_m[i]) begin
                shift_o = SW'(i);
            end
        end
        odd_m = mag_m >> shift_o;
    end

    assign idx_o   = IW'(odd_m >> 1);
    assign blank_o = (mag_m == '0);
    assign neg_o   = ~sub_in[S-1];

endmodule

// File: rtl/lutmul_apc_core.sv
module lutmul_apc_core #(
    parameter int unsigned S    = 4,
    parameter int unsigned AW   = 8,
    parameter logic [AW-1:0] COEF = '1,
    localparam int unsigned MW  = AW + S - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [S-1:0]      sub_in,
    output logic signed [MW:0] part_o
);
    localparam int unsigned NODD = 1 << (S - 2);
    localparam int unsigned SW   = $clog2(S);
    localparam logic [S-1:0] HALFV = S'(1) << (S - 1);

    logic [S-3:0]  idx;
    logic [SW-1:0] sh;
    logic          blank;
    logic          neg;
    logic [MW-1:0] odd_rom [NODD];
    logic [MW-1:0] mag;

    lutmul_addr_gen #(.S(S)) u_addr (
        .sub_in (sub_in),
        .idx_o  (idx),
        .shift_o(sh),
        .blank_o(blank),
        .neg_o  (neg)
    );

    // odd multiples of the coefficient, fixed at elaboration
    for (genvar g = 0; g < NODD; g++) begin : g_rom
        assign odd_rom[g] = MW'(COEF) * MW'(2 * g + 1);
    end

    assign mag = blank ? '0 : (odd_rom[idx] << sh);

    always_comb begin
        if (neg) begin
            part_o = (MW+1)'(0) - {1'b0, mag};
        end else begin
            part_o = {1'b0, mag};
        end
    end

    // R4: a segment with its top bit set never produces a negative partial
    p_sign_pos_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sub_in[S-1] |-> !part_o[MW]);

    // R5: the midpoint code bypasses the table and yields zero
    p_mid_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_in == HALFV) |-> (part_o == '0));

    // R6: zero segment gives minus half-range times the coefficient
    p_zero_sub_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_in == '0) |->
        ($unsigned(part_o) == ((MW+1)'(0) - ((MW+1)'(COEF) << (S - 1)))));

endmodule

// File: rtl/lutmul_base_table.sv
module lutmul_base_table #(
    parameter int unsigned SL  = 4,
    parameter int unsigned AW  = 8,
    parameter int unsigned PW  = 24,
    parameter logic [AW-1:0] COEF = '1,
    parameter logic [PW-1:0] OFS  = '0
) (
    input  logic [SL-1:0] sub_in,
    output logic [PW-1:0] val_o
);
    localparam int unsigned NB = 1 << SL;

    logic [PW-1:0] rom [NB];

    // each entry carries the folded offsets of all compact cores
    for (genvar g = 0; g < NB; g++) begin : g_rom
        assign rom[g] = PW'(COEF) * PW'(g) + OFS;
    end

    assign val_o = rom[sub_in];

endmodule

// File: rtl/lutmul_sum_tree.sv
module lutmul_sum_tree #(
    parameter int unsigned NT   = 4,
    parameter int unsigned PW   = 24,
    parameter bit          PIPE = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vld_i,
    input  logic [PW-1:0] terms_i [NT],
    output logic          vld_o,
    output logic [PW-1:0] sum_o
);
    logic [PW-1:0] src [NT];
    logic          src_vld;
    logic [PW-1:0] acc;

    if (PIPE) begin : g_stage
        logic [PW-1:0] stg_q [NT];
        logic          stg_vld_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stg_vld_q <= 1'b0;
                for (int t = 0; t < NT; t++) begin
                    stg_q[t] <= '0;
                end
            end else begin
                stg_vld_q <= vld_i;
                if (vld_i) begin
                    for (int t = 0; t < NT; t++) begin
                        stg_q[t] <= terms_i[t];
                    end
                end
            end
        end

        assign src     = stg_q;
        assign src_vld = stg_vld_q;
    end else begin : g_direct
        assign src     = terms_i;
        assign src_vld = vld_i;
    end

    // modular sum: negative partials wrap correctly in PW bits
    always_comb begin
        acc = '0;
        for (int t = 0; t < NT; t++) begin
            acc = acc + src[t];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_o <= 1'b0;
            sum_o <= '0;
        end else begin
            vld_o <= src_vld;
            if (src_vld) begin
                sum_o <= acc;
            end
        end
    end

endmodule

// File: rtl/lutmul_seg_top.sv
module lutmul_seg_top #(
    parameter int unsigned XW   = 16,
    parameter int unsigned S    = 4,
    parameter int unsigned AW   = 8,
    parameter logic [AW-1:0] COEF = 8'd173,
    parameter bit          PIPE = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [XW-1:0]      x_in,
    output logic               out_valid,
    output logic [XW+AW-1:0]   prod_out
);
    import lutmul_pkg::*;

    localparam int unsigned PW   = XW + AW;
    localparam int unsigned NOPT = lm_nopt(XW, S);
    localparam int unsigned SL   = lm_low_w(XW, S);
    localparam int unsigned NT   = NOPT + 1;
    localparam int unsigned MW   = AW + S - 1;

    function automatic logic [PW-1:0] fold_offsets();
        logic [PW-1:0] acc;
        acc = '0;
        for (int j = 0; j < NOPT; j++) begin
            acc = acc + ((PW'(COEF) << (S - 1)) << (SL + j * S));
        end
        return acc;
    endfunction

    localparam logic [PW-1:0] OFS = fold_offsets();

    logic [PW-1:0] terms [NT];

    lutmul_base_table #(
        .SL(SL), .AW(AW), .PW(PW), .COEF(COEF), .OFS(OFS)
    ) u_base (
        .sub_in(x_in[SL-1:0]),
        .val_o (terms[0])
    );

    for (genvar j = 0; j < NOPT; j++) begin : g_opt
        localparam int unsigned POS = SL + j * S;
        logic signed [MW:0] part;

        lutmul_apc_core #(.S(S), .AW(AW), .COEF(COEF)) u_core (
            .clk   (clk),
            .rst_n (rst_n),
            .sub_in(x_in[POS +: S]),
            .part_o(part)
        );

        assign terms[j+1] = PW'(part) << POS;
    end

    lutmul_sum_tree #(.NT(NT), .PW(PW), .PIPE(PIPE)) u_sum (
        .clk    (clk),
        .rst_n  (rst_n),
        .vld_i  (in_valid),
        .terms_i(terms),
        .vld_o  (out_valid),
        .sum_o  (prod_out)
    );

    if (PIPE) begin : g_chk2
        // R1: product matches the operand taken two cycles before
        p_product_r1: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (prod_out == PW'($past(x_in, 2)) * PW'(COEF)));
        // R2: no result without an accepted operand
        p_valid_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> $past(in_valid, 2));
    end else begin : g_chk1
        p_product_r1: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (prod_out == PW'($past(x_in)) * PW'(COEF)));
        p_valid_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> $past(in_valid));
    end

    // R8: the result register holds while no fresh product arrives
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(prod_out));

endmodule

// File: tb/lutmul_seg_top_tb.sv
`timescale 1ns/1ps
module lutmul_seg_top_tb;

    localparam longint AM = 173;
    localparam longint AS = 45;
    localparam longint AE = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vld = 1'b0;
    logic [15:0] xv = '0;

    logic        ov_m, ov_s, ov_e;
    logic [23:0] pm;
    logic [15:0] ps;
    logic [12:0] pe;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    lutmul_seg_top #(.XW(16), .S(4), .AW(8), .COEF(8'd173), .PIPE(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(vld), .x_in(xv),
        .out_valid(ov_m), .prod_out(pm));

    lutmul_seg_top #(.XW(10), .S(4), .AW(6), .COEF(6'd45), .PIPE(1'b0)) u_dut_s (
        .clk(clk), .rst_n(rst_n), .in_valid(vld), .x_in(xv[9:0]),
        .out_valid(ov_s), .prod_out(ps));

    lutmul_seg_top #(.XW(8), .S(3), .AW(5), .COEF(5'd20), .PIPE(1'b1)) u_dut_e (
        .clk(clk), .rst_n(rst_n), .in_valid(vld), .x_in(xv[7:0]),
        .out_valid(ov_e), .prod_out(pe));

    // bench-side history of driven operands
    logic   hv [2];
    longint hx [2];
    string  ht [2];
    longint last_m = 0, last_s = 0, last_e = 0;

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic v, input longint x, input string tag);
        string pt;
        @(negedge clk);
        // latency-1 build sees the operand driven one negedge ago
        if (hv[0]) last_s = (x_of(hx[0]) % 1024) * AS;
        pt = hv[0] ? ht[0] : "R8";
        chk("R2", "valid small", longint'(ov_s), longint'(hv[0]));
        chk(pt, "prod small", longint'(ps), last_s);
        // latency-2 builds see the operand driven two negedges ago
        if (hv[1]) begin
            last_m = hx[1] * AM;
            last_e = (hx[1] % 256) * AE;
        end
        pt = hv[1] ? ht[1] : "R8";
        chk("R2", "valid main", longint'(ov_m), longint'(hv[1]));
        chk(pt, "prod main", longint'(pm), last_m);
        chk("R2", "valid even", longint'(ov_e), longint'(hv[1]));
        chk(pt, "prod even", longint'(pe), last_e);
        hv[1] = hv[0]; hx[1] = hx[0]; ht[1] = ht[0];
        hv[0] = v;     hx[0] = x;     ht[0] = tag;
        vld = v;
        xv  = 16'(x);
    endtask

    function automatic longint x_of(input longint x);
        return x;
    endfunction

    initial begin
        hv[0] = 1'b0; hv[1] = 1'b0;
        hx[0] = 0; hx[1] = 0;
        ht[0] = "R1"; ht[1] = "R1";
        repeat (3) @(negedge clk);
        // R2: reset state
        chk("R2", "reset valid main", longint'(ov_m), 0);
        chk("R2", "reset prod main", longint'(pm), 0);
        chk("R2", "reset valid small", longint'(ov_s), 0);
        chk("R2", "reset prod even", longint'(pe), 0);
        rst_n = 1'b1;

        // R4: full sweep reaches every segment code of both small builds
        for (int v = 0; v < 1024; v++) begin
            step(1'b1, longint'(v), "R4");
        end

        // R9: extremes
        step(1'b1, 0, "R9");
        step(1'b1, 65535, "R9");
        // R3: each bit alone lands at its own weight
        for (int b = 0; b < 16; b++) begin
            step(1'b1, longint'(1) << b, "R3");
        end
        // R5: every upper segment at its midpoint
        step(1'b1, 16'h8880, "R5");
        step(1'b1, 16'h8888, "R5");
        // R6: upper segments zero, only the low segment set
        step(1'b1, 16'h000A, "R6");
        step(1'b1, 16'h0005, "R6");
        // R7: every low-segment entry with upper segments mixed
        for (int v = 0; v < 16; v++) begin
            step(1'b1, longint'(16'h3C50 | v), "R7");
        end
        // R1, R8: random stream with gaps
        for (int n = 0; n < 3000; n++) begin
            step(1'(($urandom % 4) != 0), longint'($urandom % 65536), "R1");
        end
        repeat (4) step(1'b0, 0, "R8");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule